// File: doc/BRIEF.md
# Pin Function Multiplexer with Peripheral Priority

This block sits between a bank of general-purpose pins and the on-chip peripherals that can use them. For every pin it decides whether the pad driver follows the software data and direction bits or the output and output-enable of a serial peripheral. Each peripheral occupies four consecutive pins, called slots. A one-bit location setting moves it between two base pins that are fixed per peripheral at build time. When two peripherals land on the same pin, a rotating priority order starting at a programmable peripheral index decides which one gets the pin.

Each serial peripheral runs either as a UART or as an SPI port. A mapped peripheral holds its pins whether or not it is active. The only exceptions are the two handshake slots of a UART with flow control off and the select slot of an SPI master; these are left for the next peripheral in priority order. The block also generates the pad pull-up and pull-down controls. It resynchronises the pad inputs through two flops and hands that value to the GPIO read path and to every slot of every peripheral at its mapped pins.

Top module: `pin_func_mux`

## Requirements
- R1: A pin whose select bit is 0 drives `gpio_dout` and `gpio_dir` to `pad_out` and `pad_oe`.
- R2: A pin whose select bit is 1 and that a peripheral owns drives that peripheral's slot output and enable, where the slot is the pin index minus the peripheral's base. Slot s of peripheral p is bit p*4+s of `per_out`, `per_oe` and `per_in`.
- R3: `per_loc[p]`=0 puts peripheral p at base LOC_A[p] and 1 puts it at LOC_B[p]. The defaults are peripheral 0 at 0 or 4 and peripheral 1 at 2 or 4.
- R4: Competing claims go to the first claimant in the order prio_first, prio_first+1, and so on, modulo NPER.
- R5: A mapped peripheral keeps its pins even when its output enables are all 0, and the pins then stay undriven.
- R6: In UART mode (`per_spi[p]`=0) with `per_flow_en[p]`=0, slots 2 and 3 are not claimed.
- R7: In SPI mode with `per_master[p]`=1, slot 3 is not claimed. An SPI slave claims all four slots.
- R8: A pin with select 1 that no peripheral claims falls back to `gpio_dout`/`gpio_dir`.
- R9: `pad_pu` = ~sel & pull_en & pull_up and `pad_pd` = ~sel & pull_en & ~pull_up. The two are never both 1.
- R10: `gpio_din` and every `per_in` slot show the pad value after two clock edges. The value ignores select and pull settings.
- R11: During reset the synchronizer reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw pad input levels |
| gpio_dout | input | NPINS | Software output data |
| gpio_dir | input | NPINS | Software direction, 1 = output |
| pin_sel | input | NPINS | 1 = pin offered to peripherals |
| pull_en | input | NPINS | Pull resistor enable |
| pull_up | input | NPINS | 1 = pull up, 0 = pull down |
| per_loc | input | NPER | Location choice per peripheral |
| prio_first | input | PW | Index of highest-priority peripheral |
| per_spi | input | NPER | 1 = SPI mode, 0 = UART mode |
| per_flow_en | input | NPER | UART flow control enable |
| per_master | input | NPER | SPI master mode |
| per_out | input | NPER*4 | Peripheral slot output data |
| per_oe | input | NPER*4 | Peripheral slot output enables |
| per_in | output | NPER*4 | Synchronized pin value per slot |
| gpio_din | output | NPINS | Synchronized pin values |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_pd | output | NPINS | Pad pull-down enable |

## Verification
The mux is driven with a grid of location, priority and mode settings. In that grid the two peripherals have mirror-image slot outputs (0101 against 1010), so the pattern on each pin shows which peripheral and which slot reached it. Overlapping and disjoint placements tell priority resolution apart from plain mapping. The mode rows change only the released slots, so a pin moving to the other peripheral or back to GPIO shows the release rule in isolation. Directed cases mix GPIO data and direction values to show fallback. A pad pattern with distinct bits shows the slot fan-out and the two-edge latency.

// File: rtl/pin_func_mux.sv
`timescale 1ns/1ps
module pin_func_mux #(
  parameter int NPINS = 8,
  parameter int NPER = 2,
  parameter int LOC_A [NPER] = '{0, 2},
  parameter int LOC_B [NPER] = '{4, 4},
  localparam int SLOTS = 4,
  localparam int PW = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_in,
  input  logic [NPINS-1:0]       gpio_dout,
  input  logic [NPINS-1:0]       gpio_dir,
  input  logic [NPINS-1:0]       pin_sel,
  input  logic [NPINS-1:0]       pull_en,
  input  logic [NPINS-1:0]       pull_up,
  input  logic [NPER-1:0]        per_loc,
  input  logic [PW-1:0]          prio_first,
  input  logic [NPER-1:0]        per_spi,
  input  logic [NPER-1:0]        per_flow_en,
  input  logic [NPER-1:0]        per_master,
  input  logic [NPER*SLOTS-1:0]  per_out,
  input  logic [NPER*SLOTS-1:0]  per_oe,
  output logic [NPER*SLOTS-1:0]  per_in,
  output logic [NPINS-1:0]       gpio_din,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_pu,
  output logic [NPINS-1:0]       pad_pd
);

  logic [NPINS-1:0] sync1, sync2;
  logic [NPER*SLOTS-1:0] released;
  logic [NPINS-1:0] owned, own_out, own_oe, use_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  assign gpio_din = sync2;

  for (genvar p = 0; p < NPER; p++) begin : g_per
    // UART: slots 2/3 are handshake; SPI: slot 3 is select
    assign released[p*SLOTS+0] = 1'b0;
    assign released[p*SLOTS+1] = 1'b0;
    assign released[p*SLOTS+2] = !per_spi[p] && !per_flow_en[p];
    assign released[p*SLOTS+3] = per_spi[p] ? per_master[p] : !per_flow_en[p];
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign per_in[p*SLOTS+k] = per_loc[p] ? sync2[LOC_B[p]+k] : sync2[LOC_A[p]+k];
    end
  end

  always_comb begin
    owned   = '0;
    own_out = '0;
    own_oe  = '0;
    for (int i = 0; i < NPINS; i++) begin
      for (int r = 0; r < NPER; r++) begin
        int p, b, k;
        p = (int'(prio_first) + r) % NPER;
        b = per_loc[p] ? LOC_B[p] : LOC_A[p];
        k = i - b;
        if (!owned[i] && k >= 0 && k < SLOTS) begin
          if (!released[p*SLOTS+k]) begin
            owned[i]   = 1'b1;
            own_out[i] = per_out[p*SLOTS+k];
            own_oe[i]  = per_oe[p*SLOTS+k];
          end
        end
      end
    end
  end

  assign use_per = pin_sel & owned;
  assign pad_out = (use_per & own_out) | (~use_per & gpio_dout);
  assign pad_oe  = (use_per & own_oe)  | (~use_per & gpio_dir);
  assign pad_pu  = ~pin_sel & pull_en & pull_up;
  assign pad_pd  = ~pin_sel & pull_en & ~pull_up;

endmodule

// File: rtl/pin_func_mux_chk.sv
`timescale 1ns/1ps
module pin_func_mux_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_sel,
  input logic [NPINS-1:0] gpio_dout,
  input logic [NPINS-1:0] gpio_dir,
  input logic [NPINS-1:0] gpio_din,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] pad_pd
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  a_r9_sel_blocks_pull: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu | pad_pd) & pin_sel) == '0);

  a_r1_gpio_path: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ gpio_dout) | (pad_oe ^ gpio_dir)) & ~pin_sel) == '0);

  a_r10_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (gpio_din == $past(pin_in, 2)));

endmodule

bind pin_func_mux pin_func_mux_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sel(pin_sel),
  .gpio_dout(gpio_dout), .gpio_dir(gpio_dir), .gpio_din(gpio_din),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/sim_pin_func_mux.sv
`timescale 1ns/1ps
module sim_pin_func_mux;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pin_in, gpio_dout, gpio_dir, pin_sel, pull_en, pull_up;
  logic [1:0] per_loc, per_spi, per_flow_en, per_master;
  logic [0:0] prio_first;
  logic [7:0] per_out, per_oe, per_in, gpio_din, pad_out, pad_oe, pad_pu, pad_pd;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pin_func_mux u0 (.*);

  // {sel, loc, prio, spi, flow, master, oe, exp_out, exp_oe}
  localparam int NV = 11;
  localparam logic [40:0] VEC [NV] = '{
    {8'hFF, 2'b00, 1'b0, 2'b00, 2'b11, 2'b00, 8'hFF, 8'h25, 8'h3F},
    {8'hFF, 2'b00, 1'b1, 2'b00, 2'b11, 2'b00, 8'hFF, 8'h29, 8'h3F},
    {8'h00, 2'b00, 1'b0, 2'b00, 2'b11, 2'b00, 8'hFF, 8'h00, 8'h00},
    {8'hFF, 2'b01, 1'b0, 2'b00, 2'b11, 2'b00, 8'hFF, 8'h58, 8'hFC},
    {8'hFF, 2'b11, 1'b1, 2'b00, 2'b11, 2'b00, 8'hFF, 8'hA0, 8'hF0},
    {8'hFF, 2'b11, 1'b0, 2'b00, 2'b10, 2'b00, 8'hFF, 8'h90, 8'hF0},
    {8'hFF, 2'b11, 1'b0, 2'b00, 2'b00, 2'b00, 8'hFF, 8'h10, 8'h30},
    {8'hFF, 2'b11, 1'b0, 2'b01, 2'b11, 2'b01, 8'hFF, 8'hD0, 8'hF0},
    {8'hFF, 2'b11, 1'b0, 2'b01, 2'b11, 2'b00, 8'hFF, 8'h50, 8'hF0},
    {8'h0C, 2'b00, 1'b0, 2'b00, 2'b11, 2'b00, 8'hFF, 8'h04, 8'h0C},
    {8'hFF, 2'b11, 1'b0, 2'b00, 2'b11, 2'b00, 8'hF0, 8'h50, 8'h00}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2 R3 R4";
      1: return "R4";
      2: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R6";
      6: return "R6 R8";
      7: return "R7";
      8: return "R7";
      9: return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    pin_in = 8'hFF; gpio_dout = 8'h00; gpio_dir = 8'h00; pin_sel = 8'h00;
    pull_en = 8'h00; pull_up = 8'h00; per_loc = 2'b00; prio_first = 1'b0;
    per_spi = 2'b00; per_flow_en = 2'b11; per_master = 2'b00;
    per_out = 8'hA5; per_oe = 8'hFF;
    #11;
    chk("R11 gpio_din", gpio_din, 8'h00);
    chk("R11 per_in", per_in, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {pin_sel, per_loc, prio_first, per_spi, per_flow_en, per_master, per_oe} = VEC[i][40:16];
      #1;
      chk({tag_of(i), " pad_out"}, pad_out, VEC[i][15:8]);
      chk({tag_of(i), " pad_oe"}, pad_oe, VEC[i][7:0]);
    end

    per_oe = 8'hFF; per_spi = 2'b00; per_flow_en = 2'b11; per_master = 2'b00;
    per_loc = 2'b00; prio_first = 1'b0;
    pin_sel = 8'h00; gpio_dout = 8'hA5; gpio_dir = 8'h3C; #1;
    chk("R1 gpio out", pad_out, 8'hA5);
    chk("R1 gpio dir", pad_oe, 8'h3C);

    pin_sel = 8'hFF; gpio_dout = 8'hFF; gpio_dir = 8'hFF; #1;
    chk("R8 fallback out", pad_out, 8'hE5);
    chk("R8 fallback oe", pad_oe, 8'hFF);

    pin_sel = 8'h33; pull_en = 8'hFF; pull_up = 8'h0F; #1;
    chk("R9 pull up", pad_pu, 8'h0C);
    chk("R9 pull down", pad_pd, 8'hC0);
    pull_en = 8'h00; #1;
    chk("R9 pull off", pad_pu | pad_pd, 8'h00);

    pin_sel = 8'hFF; pull_en = 8'hFF; per_loc = 2'b01;
    @(negedge clk); pin_in = 8'h00;
    @(negedge clk); @(negedge clk);
    pin_in = 8'hB4;
    @(negedge clk);
    chk("R10 one edge", gpio_din, 8'h00);
    @(negedge clk);
    chk("R10 two edges", gpio_din, 8'hB4);
    chk("R10 slot fanout", per_in, 8'hDB);

    finish_run();
  end
endmodule